// File: doc/BRIEF.md
# Triggered One-Pulse Generator

This block waits, idle, for a chosen edge on an asynchronous trigger line and then emits exactly one pulse. The edge starts a free-running up-counter that begins at zero. The counter stops by itself at the update event, which is the cycle it would roll from the period value back to zero. While it runs, the output is shaped by comparing the counter with a compare value. In PWM mode 2 the delay before the pulse equals the compare value and the pulse lasts period minus compare cycles.

The trigger passes through a synchronizer and an edge detector. Edges that arrive while a pulse is in progress are dropped. A fast-enable option makes the output take its post-match level from the first counting cycle, so the output moves with the least possible latency after the trigger. After the counter stops it holds zero and the output returns low until the next accepted edge.

Top module: `opulse_gen`

## Requirements
- R1: With `trig_fall_sel`=0 only a 0-to-1 change of `trig_in` starts a pulse, and with `trig_fall_sel`=1 only a 1-to-0 change does. A change in the other direction leaves `busy` low.
- R2: `busy` rises on the third rising clock edge after `trig_in` changes: two synchronizer stages, then the edge register. The counter holds 0 in the first busy cycle.
- R3: While busy, the counter advances by one each cycle. When the counter equals `per_val`, busy drops at the next edge and the counter returns to 0, so `busy` stays high for `per_val`+1 cycles.
- R4: Trigger edges that arrive while `busy` is high are ignored and do not lengthen or restart the run.
- R5: With `out_mode`=2'b11 (PWM mode 2) and no fast enable, `pulse_out` is high while busy and the counter lies in [`cmp_val`, `per_val`-1]. That gives a delay of `cmp_val` cycles after busy rises and a width of `per_val`-`cmp_val` cycles.
- R6: With `out_mode`=2'b10 (PWM mode 1) and no fast enable, `pulse_out` is high while busy and the counter is below `cmp_val`.
- R7: When `fast_en` is high at the accepted edge in a PWM mode, the output acts as if the compare match had already happened. In mode 2 it is high from the first busy cycle until the counter reaches `per_val`. In mode 1 it stays low for the whole run.
- R8: With `out_mode` 2'b00 or 2'b01, `pulse_out` stays low and `fast_en` has no effect. The counter still runs for one period.
- R9: After reset, `busy` and `pulse_out` are 0.
- R10: Whenever `busy` is low, `pulse_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger line |
| trig_fall_sel | input | 1 | 0: rising edge starts, 1: falling edge starts |
| fast_en | input | 1 | Force post-match output level at start (PWM modes only) |
| out_mode | input | 2 | 2'b11 PWM mode 2, 2'b10 PWM mode 1, others output off |
| cmp_val | input | CNT_W | Compare value (delay) |
| per_val | input | CNT_W | Period value (update point) |
| pulse_out | output | 1 | Pulse output |
| busy | output | 1 | Counter enabled |

## Verification
The assertions assume that `out_mode`, `fast_en`, `cmp_val` and `per_val` stay stable for a whole run. They also assume 0 < `cmp_val` < `per_val`, which is the range in which a well-formed pulse exists. The stimulus changes those inputs only while the block is idle. Random runs draw the period from 8 to 40 and the compare value strictly inside it. Directed runs cover a period of 2 with a compare of 1, a compare one below the period, and trigger toggles during a run. Before every run the trigger is moved to its inactive level while idle, which also exercises the ignored edge direction.

// File: rtl/opulse_pkg.sv
package opulse_pkg;
   typedef enum logic [1:0] {
      OM_OFF0 = 2'b00,
      OM_OFF1 = 2'b01,
      OM_PWM1 = 2'b10,
      OM_PWM2 = 2'b11
   } out_mode_e;

   function automatic logic is_pwm(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/opulse_trig_sync.sv
module opulse_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic fall_sel,
   output logic edge_det
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] stage_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= 1'b0;
      else        stage_q[0] <= trig_in;
   end

   for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[g] <= 1'b0;
         else        stage_q[g] <= stage_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= stage_q[SYNC_STAGES-1];
   end

   always_comb begin
      if (fall_sel) edge_det = last_q & ~stage_q[SYNC_STAGES-1];
      else          edge_det = ~last_q & stage_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/opulse_counter.sv
module opulse_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fast_arm,
   input  logic [CNT_W-1:0] per_val,
   output logic             running,
   output logic             fast_q,
   output logic [CNT_W-1:0] cnt
);
   logic at_update;
   assign at_update = running && (cnt == per_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         fast_q  <= 1'b0;
         cnt     <= '0;
      end else if (running) begin
         if (at_update) begin
            running <= 1'b0;
            fast_q  <= 1'b0;
            cnt     <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end else if (start) begin
         running <= 1'b1;
         fast_q  <= fast_arm;
         cnt     <= '0;
      end
   end

   // R3: counter steps by one while running and below the update point
   p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running && (cnt != per_val) |=> running && (cnt == $past(cnt) + CNT_W'(1)));
   // R3: update event ends the run and clears the counter
   p_update_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running && (cnt == per_val) |=> !running && (cnt == '0));
   // R2: accepted start begins at zero
   p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !running && start |=> running && (cnt == '0));
   // R4: a start request during a run does not restart it
   p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running && start && (cnt != per_val) |=> cnt != '0);
endmodule

// File: rtl/opulse_shaper.sv
module opulse_shaper
   import opulse_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             fast_q,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] per_val,
   output logic             pulse
);
   logic below_cmp;
   logic below_per;
   assign below_cmp = cnt < cmp_val;
   assign below_per = cnt < per_val;

   always_comb begin
      pulse = 1'b0;
      if (running) begin
         unique case (out_mode_e'(mode))
            OM_PWM2: pulse = (!below_cmp || fast_q) && below_per;
            OM_PWM1: pulse = below_cmp && !fast_q;
            default: pulse = 1'b0;
         endcase
      end
   end

   // R10: no output outside a run
   p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !pulse);
   // R8: non-PWM modes keep the output low
   p_off_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |-> !pulse);
   // R7: fast start in mode 1 means the post-match (low) level throughout
   p_fast_pwm1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fast_q && (mode == OM_PWM1) |-> !pulse);
   // R5: pulse falls once the counter reaches the period
   p_fall_at_per_r5: assert property (@(posedge clk) disable iff (!rst_n)
      running && (mode == OM_PWM2) && (cnt == per_val) |-> !pulse);
endmodule

// File: rtl/opulse_gen.sv
module opulse_gen
   import opulse_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             trig_fall_sel,
   input  logic             fast_en,
   input  logic [1:0]       out_mode,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] per_val,
   output logic             pulse_out,
   output logic             busy
);
   initial begin
      if (CNT_W < 2) $error("CNT_W must be at least 2");
   end

   logic             trig_edge;
   logic             running;
   logic             fast_q;
   logic [CNT_W-1:0] cnt;

   opulse_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .fall_sel (trig_fall_sel),
      .edge_det (trig_edge)
   );

   opulse_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (trig_edge),
      .fast_arm (fast_en && is_pwm(out_mode)),
      .per_val  (per_val),
      .running  (running),
      .fast_q   (fast_q),
      .cnt      (cnt)
   );

   opulse_shaper #(.CNT_W(CNT_W)) u_shape (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (running),
      .fast_q  (fast_q),
      .mode    (out_mode),
      .cnt     (cnt),
      .cmp_val (cmp_val),
      .per_val (per_val),
      .pulse   (pulse_out)
   );

   assign busy = running;

   // R8: fast enable is never armed outside a PWM mode
   p_fast_only_pwm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !running && trig_edge && !out_mode[1] |=> !fast_q);
endmodule

// File: tb/opulse_gen_tb.sv
module opulse_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int WATCHDOG   = 100000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trig_in = 1'b0;
   logic             trig_fall_sel = 1'b0;
   logic             fast_en = 1'b0;
   logic [1:0]       out_mode = 2'b11;
   logic [CNT_W-1:0] cmp_val = 16'd1;
   logic [CNT_W-1:0] per_val = 16'd2;
   logic             pulse_out;
   logic             busy;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opulse_gen #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_fall_sel(trig_fall_sel),
      .fast_en(fast_en), .out_mode(out_mode), .cmp_val(cmp_val), .per_val(per_val),
      .pulse_out(pulse_out), .busy(busy)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
      end
   endtask

   // Expected output from R5..R8 given counter value c within a run
   function automatic logic exp_pulse(input int c, input logic run, input int cmp,
                                      input int per, input logic [1:0] m, input logic f);
      logic ff;
      ff = f && m[1];
      if (!run) return 1'b0;
      case (m)
         2'b11:   return ((c >= cmp) || ff) && (c < per);
         2'b10:   return (c < cmp) && !ff;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string out_tag(input logic [1:0] m, input logic f);
      if (!m[1]) return "R8";
      if (f)     return "R7";
      return (m == 2'b11) ? "R5" : "R6";
   endfunction

   // Move trigger to the inactive level while idle: no run may start (R1), output low (R10)
   task automatic idle_level(input logic lvl);
      @(negedge clk);
      trig_in = lvl;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R1", busy, 1'b0);
         check("R10", pulse_out, 1'b0);
      end
   endtask

   task automatic shot(input logic fall, input int cmp, input int per,
                       input logic [1:0] m, input logic f, input logic toggles);
      string btag;
      @(negedge clk);
      trig_fall_sel = fall;
      cmp_val = CNT_W'(cmp);
      per_val = CNT_W'(per);
      out_mode = m;
      fast_en = f;
      idle_level(fall);
      trig_in = ~fall;
      btag = toggles ? "R4" : (fall ? "R1" : "R3");
      for (int j = 1; j <= per + 8; j++) begin
         logic eb;
         @(posedge clk);
         @(negedge clk);
         if (toggles && (j == 5 || j == 7)) trig_in = ~trig_in;
         eb = (j >= 3) && (j <= 3 + per);
         if (j == 3) check("R2", busy, 1'b1);
         else        check(btag, busy, eb);
         check(out_tag(m, f), pulse_out, exp_pulse(j - 3, eb, cmp, per, m, f));
      end
   endtask

   initial begin
      for (int w = 0; w < WATCHDOG && !done; w++) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R9", busy, 1'b0);
      check("R9", pulse_out, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", busy, 1'b0);

      shot(1'b0, 1, 2, 2'b11, 1'b0, 1'b0);    // minimum period
      shot(1'b0, 9, 10, 2'b11, 1'b0, 1'b0);   // compare one below period
      shot(1'b0, 4, 8, 2'b10, 1'b0, 1'b0);    // mode 1
      shot(1'b0, 4, 8, 2'b11, 1'b1, 1'b0);    // fast, mode 2
      shot(1'b0, 4, 8, 2'b10, 1'b1, 1'b0);    // fast, mode 1
      shot(1'b0, 3, 8, 2'b00, 1'b1, 1'b0);    // off mode ignores fast
      shot(1'b0, 3, 8, 2'b01, 1'b0, 1'b0);
      shot(1'b1, 5, 12, 2'b11, 1'b0, 1'b0);   // falling edge start
      shot(1'b0, 5, 12, 2'b11, 1'b0, 1'b1);   // toggles during run ignored
      shot(1'b1, 2, 9, 2'b10, 1'b0, 1'b1);

      for (int n = 0; n < 40; n++) begin
         int per, cmp;
         logic [1:0] m;
         per = $urandom_range(40, 8);
         cmp = $urandom_range(per - 1, 1);
         m   = 2'($urandom_range(3, 0));
         shot(1'($urandom_range(1, 0)), cmp, per, m,
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule